// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a translation miss by walking a radix page table of four levels. When idle it accepts a virtual address together with the current value of the translation base register. The base register gives the physical page of the top-level table and, in its upper spare bits, the address space identifier that is active. The walker then issues one descriptor read per level on a simple read request/response port. Each descriptor names the table of the next level, or at the last level the physical page. Every read depends on the one before it.

When the walk ends, the walker holds a one-cycle done pulse. With it come the virtual page, the physical page, the non-global flag taken from the leaf descriptor and the captured address space identifier, all ready to be written into the translation cache. A descriptor with its valid bit clear at any level ends the walk early. The block then reports a fault and the level that failed.

Top module: `radix_walker`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and mem_rd_valid is 0.
- R2: A request is taken only when req_valid and req_ready are both 1. req_ready stays 0 from that acceptance until the cycle after done. Values on req_valid, req_va and base_reg while busy change no read address and no result.
- R3: The first read goes to base_reg[47:12] shifted left by 12, plus 8 times the index va[47:39].
- R4: Levels are read in the fixed order 0 to 3, with indices va[47:39], va[38:30], va[29:21] and va[20:12]. A valid non-leaf descriptor gives the next table page in bits [47:12]. A walk without fault makes exactly four reads.
- R5: On success, fill_ppn equals bits [47:12] of the level-3 descriptor, fill_vpn equals va[47:12] and fill_fault is 0.
- R6: fill_ng equals bit 11 of the level-3 descriptor. Bit 11 of the descriptors at levels 0 to 2 has no effect on it.
- R7: fill_asid equals base_reg[63:48] as sampled when the request was accepted.
- R8: A descriptor with bit 0 clear ends the walk. No further read is made, fill_fault is 1, fill_fault_lvl gives that level (0 to 3), and fill_ppn and fill_ng read 0.
- R9: done rises in the cycle after the final response is taken and lasts exactly one cycle.
- R10: While mem_rd_valid is 1 and mem_rd_ready is 0, the request stays asserted with an unchanged mem_rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 48 | Virtual address that missed |
| base_reg | input | 64 | Table base page in [47:12], ASID in [63:48] |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 48 | Physical byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 64 | Descriptor: valid in bit 0, non-global in bit 11, page in [47:12] |
| done | output | 1 | One-cycle completion pulse |
| fill_fault | output | 1 | Walk ended on an invalid descriptor |
| fill_fault_lvl | output | 2 | Level of the invalid descriptor |
| fill_vpn | output | 36 | Virtual page of the walk |
| fill_asid | output | 16 | ASID captured at acceptance |
| fill_ppn | output | 36 | Physical page from the leaf |
| fill_ng | output | 1 | Non-global flag from the leaf |

## Verification
Two functions can fall in the same cycle: the completion pulse of one walk and the arrival of the next request. The bench provokes this by raising req_valid with a second address and base while the first walk is still waiting for its leaf, and keeps it raised through done. It judges that req_ready is low in the done cycle and that the held request is taken only in the following cycle. The second walk's first read address must come from the new base and address, and the first walk's result must not be disturbed. Requests raised in the middle of a walk are checked the same way against the read addresses that follow.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ISSUE = 2'd1,
    WK_WAIT  = 2'd2,
    WK_DONE  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/rwalk_addr.sv
module rwalk_addr #(
  parameter int VPN_W    = 36,
  parameter int PPN_W    = 36,
  parameter int PA_W     = 48,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 9,
  parameter int LEVELS   = 4,
  parameter int DESC_W   = 64,
  localparam int LVL_W   = $clog2(LEVELS),
  localparam int OFS_SH  = $clog2(DESC_W / 8)
) (
  input  logic [PPN_W-1:0] tbl_ppn,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  rd_addr
);
  logic [IDX_W-1:0] idx_by_lvl [LEVELS];

  // level 0 takes the most significant index slice
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_by_lvl[g] = vpn[IDX_W*(LEVELS-g)-1 -: IDX_W];
  end

  function automatic logic [PA_W-1:0] table_byte_addr(input logic [PPN_W-1:0] ppn);
    return {ppn, {PG_SHIFT{1'b0}}};
  endfunction

  function automatic logic [PA_W-1:0] entry_offset(input logic [IDX_W-1:0] idx);
    return {{(PA_W-IDX_W-OFS_SH){1'b0}}, idx, {OFS_SH{1'b0}}};
  endfunction

  assign rd_addr = table_byte_addr(tbl_ppn) + entry_offset(idx_by_lvl[lvl]);
endmodule

// File: rtl/rwalk_ctrl.sv
module rwalk_ctrl
  import rwalk_pkg::*;
#(
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             mem_rd_ready,
  input  logic             mem_rsp_valid,
  input  logic             desc_ok,
  output logic             req_ready,
  output logic             rd_valid,
  output logic             done,
  output logic             ev_accept,
  output logic             ev_step,
  output logic             ev_leaf,
  output logic             ev_fault,
  output logic [LVL_W-1:0] lvl
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_state_e state_q, state_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic rsp_take;

  assign req_ready = (state_q == WK_IDLE);
  assign rd_valid  = (state_q == WK_ISSUE);
  assign done      = (state_q == WK_DONE);
  assign lvl       = lvl_q;

  assign ev_accept = req_valid && req_ready;
  assign rsp_take  = (state_q == WK_WAIT) && mem_rsp_valid;
  assign ev_fault  = rsp_take && !desc_ok;
  assign ev_leaf   = rsp_take && desc_ok && (lvl_q == LAST_LVL);
  assign ev_step   = rsp_take && desc_ok && (lvl_q != LAST_LVL);

  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    unique case (state_q)
      WK_IDLE: if (ev_accept) begin
        state_d = WK_ISSUE;
        lvl_d   = '0;
      end
      WK_ISSUE: if (mem_rd_ready) state_d = WK_WAIT;
      WK_WAIT: begin
        if (ev_step) begin
          state_d = WK_ISSUE;
          lvl_d   = lvl_q + 1'b1;
        end else if (ev_leaf || ev_fault) begin
          state_d = WK_DONE;
        end
      end
      WK_DONE: state_d = WK_IDLE;
      default: state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      lvl_q   <= '0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
    end
  end
endmodule

// File: rtl/rwalk_dp.sv
module rwalk_dp #(
  parameter int VA_W     = 48,
  parameter int PA_W     = 48,
  parameter int BASE_W   = 64,
  parameter int ASID_W   = 16,
  parameter int DESC_W   = 64,
  parameter int PG_SHIFT = 12,
  parameter int NG_BIT   = 11,
  parameter int LEVELS   = 4,
  localparam int VPN_W   = VA_W - PG_SHIFT,
  localparam int PPN_W   = PA_W - PG_SHIFT,
  localparam int LVL_W   = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_accept,
  input  logic              ev_step,
  input  logic              ev_leaf,
  input  logic              ev_fault,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [VA_W-1:0]   req_va,
  input  logic [BASE_W-1:0] base_reg,
  input  logic [DESC_W-1:0] rsp_data,
  output logic [VPN_W-1:0]  vpn,
  output logic [PPN_W-1:0]  tbl_ppn,
  output logic [ASID_W-1:0] asid,
  output logic [PPN_W-1:0]  res_ppn,
  output logic              res_ng,
  output logic              res_fault,
  output logic [LVL_W-1:0]  res_lvl
);
  function automatic logic [PPN_W-1:0] desc_page(input logic [DESC_W-1:0] d);
    return d[PA_W-1:PG_SHIFT];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpn       <= '0;
      tbl_ppn   <= '0;
      asid      <= '0;
      res_ppn   <= '0;
      res_ng    <= 1'b0;
      res_fault <= 1'b0;
      res_lvl   <= '0;
    end else begin
      if (ev_accept) begin
        vpn     <= req_va[VA_W-1:PG_SHIFT];
        tbl_ppn <= base_reg[PA_W-1:PG_SHIFT];
        asid    <= base_reg[BASE_W-1 -: ASID_W];
      end
      if (ev_step) tbl_ppn <= desc_page(rsp_data);
      if (ev_leaf) begin
        res_ppn   <= desc_page(rsp_data);
        res_ng    <= rsp_data[NG_BIT];
        res_fault <= 1'b0;
        res_lvl   <= lvl;
      end
      if (ev_fault) begin
        res_ppn   <= '0;
        res_ng    <= 1'b0;
        res_fault <= 1'b1;
        res_lvl   <= lvl;
      end
    end
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int VA_W     = 48,
  parameter int PA_W     = 48,
  parameter int BASE_W   = 64,
  parameter int ASID_W   = 16,
  parameter int DESC_W   = 64,
  parameter int PG_SHIFT = 12,
  parameter int IDX_W    = 9,
  parameter int NG_BIT   = 11,
  parameter int LEVELS   = 4,
  localparam int VPN_W   = VA_W - PG_SHIFT,
  localparam int PPN_W   = PA_W - PG_SHIFT,
  localparam int LVL_W   = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [BASE_W-1:0] base_reg,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              fill_fault,
  output logic [LVL_W-1:0]  fill_fault_lvl,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [ASID_W-1:0] fill_asid,
  output logic [PPN_W-1:0]  fill_ppn,
  output logic              fill_ng
);
  // internal events, named for the checker
  logic ev_accept, ev_step, ev_leaf, ev_fault;
  logic [LVL_W-1:0] lvl;
  logic [PPN_W-1:0] tbl_ppn;
  logic [VPN_W-1:0] vpn;
  logic desc_ok;

  assign desc_ok = mem_rsp_data[0];

  rwalk_ctrl #(.LEVELS(LEVELS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .desc_ok      (desc_ok),
    .req_ready    (req_ready),
    .rd_valid     (mem_rd_valid),
    .done         (done),
    .ev_accept    (ev_accept),
    .ev_step      (ev_step),
    .ev_leaf      (ev_leaf),
    .ev_fault     (ev_fault),
    .lvl          (lvl)
  );

  rwalk_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .BASE_W(BASE_W), .ASID_W(ASID_W),
    .DESC_W(DESC_W), .PG_SHIFT(PG_SHIFT), .NG_BIT(NG_BIT), .LEVELS(LEVELS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_accept(ev_accept),
    .ev_step  (ev_step),
    .ev_leaf  (ev_leaf),
    .ev_fault (ev_fault),
    .lvl      (lvl),
    .req_va   (req_va),
    .base_reg (base_reg),
    .rsp_data (mem_rsp_data),
    .vpn      (vpn),
    .tbl_ppn  (tbl_ppn),
    .asid     (fill_asid),
    .res_ppn  (fill_ppn),
    .res_ng   (fill_ng),
    .res_fault(fill_fault),
    .res_lvl  (fill_fault_lvl)
  );

  rwalk_addr #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT),
    .IDX_W(IDX_W), .LEVELS(LEVELS), .DESC_W(DESC_W)
  ) u_addr (
    .tbl_ppn(tbl_ppn),
    .vpn    (vpn),
    .lvl    (lvl),
    .rd_addr(mem_rd_addr)
  );

  assign fill_vpn = vpn;
endmodule

// File: rtl/rwalk_chk.sv
module rwalk_chk #(
  parameter int PA_W   = 48,
  parameter int LEVELS = 4,
  localparam int CNT_W = $clog2(LEVELS + 1) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_rd_valid,
  input logic            mem_rd_ready,
  input logic [PA_W-1:0] mem_rd_addr,
  input logic            done,
  input logic            fill_fault,
  input logic            ev_leaf,
  input logic            ev_fault
);
  logic [CNT_W-1:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_cnt <= '0;
    else if (req_valid && req_ready) rd_cnt <= '0;
    else if (mem_rd_valid && mem_rd_ready) rd_cnt <= rd_cnt + 1'b1;
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4
  read_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= CNT_W'(LEVELS));

  // R4
  full_walk_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fill_fault) |-> rd_cnt == CNT_W'(LEVELS));

  // R5
  leaf_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_leaf |=> done && !fill_fault);

  // R8
  fault_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> done && fill_fault && !mem_rd_valid);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr));
endmodule

bind radix_walker rwalk_chk #(.PA_W(PA_W), .LEVELS(LEVELS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr (mem_rd_addr),
  .done        (done),
  .fill_fault  (fill_fault),
  .ev_leaf     (ev_leaf),
  .ev_fault    (ev_fault)
);

// File: tb/radix_walker_test.sv
module radix_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic [63:0] base_reg = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [47:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done, fill_fault, fill_ng;
  logic [1:0]  fill_fault_lvl;
  logic [35:0] fill_vpn, fill_ppn;
  logic [15:0] fill_asid;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  radix_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .base_reg(base_reg), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
    .fill_fault(fill_fault), .fill_fault_lvl(fill_fault_lvl), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_ppn(fill_ppn), .fill_ng(fill_ng)
  );

  localparam int NV = 6;
  localparam logic [47:0] T_VA [NV] = '{
    48'h0000_1234_5000, 48'hFFFF_FFFF_F000, 48'h0000_0040_0000,
    48'h7F80_4020_1000, 48'h1000_0000_3000, 48'h8000_0000_0000};
  localparam logic [63:0] T_BASE [NV] = '{
    64'h0001_0000_0010_0000, 64'hBEEF_8000_0000_0000, 64'h0002_0000_0005_0000,
    64'h0003_0000_0001_0000, 64'h00FF_0000_0009_0000, 64'hFFFF_0000_0000_1000};
  localparam logic [63:0] T_DESC [NV][4] = '{
    '{64'h0000_0000_0020_0801, 64'h0000_0000_0030_0801, 64'h0000_0000_0040_0801, 64'h0000_000A_BCDE_0001},
    '{64'h0000_7FFF_FFFF_F001, 64'h0000_1000_0000_0001, 64'h0000_2000_0000_0001, 64'hFFFF_FFFF_FFFF_F801},
    '{64'h0000_0000_0006_0800, 64'h0000_0000_0007_0001, 64'h0000_0000_0008_0001, 64'h0000_0000_0009_0001},
    '{64'h0000_0000_0002_0001, 64'h0000_0000_0003_0001, 64'h0000_0000_0004_0000, 64'h0000_0000_0005_0001},
    '{64'h0000_0000_000A_0001, 64'h0000_0000_000B_0001, 64'h0000_0000_000C_0001, 64'h0000_0000_0DEA_D800},
    '{64'h0000_0000_0000_2001, 64'h0000_0000_0000_3001, 64'h0000_0000_0000_4001, 64'h0000_1234_5678_9801}};
  localparam int T_STALL [NV] = '{0, 2, 0, 1, 3, 0};
  localparam bit T_NOISE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // collide: keep (cva, cbase) raised through done; preissued: request already held
  task automatic run_walk(input int v, input bit collide, input logic [47:0] cva,
                          input logic [63:0] cbase, input bit preissued);
    logic [47:0] va;
    logic [63:0] base;
    logic [35:0] tbl;
    logic [47:0] exp_addr;
    logic [8:0]  idx;
    bit ended;
    va = T_VA[v];
    base = T_BASE[v];
    tbl = base[47:12];
    ended = 1'b0;
    if (!preissued) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_va = va;
      base_reg = base;
      check(req_ready == 1'b1, "R2", 64'(req_ready), 64'd1);
    end
    @(negedge clk);
    req_valid = 1'b0;
    req_va = '0;
    base_reg = '0;
    check(req_ready == 1'b0, "R2", 64'(req_ready), 64'd0);
    for (int lvl = 0; lvl < 4 && !ended; lvl++) begin
      idx = 9'((va >> (39 - 9 * lvl)) & 48'h1FF);
      exp_addr = (48'(tbl) << 12) | (48'(idx) << 3);
      check(mem_rd_valid == 1'b1, lvl == 0 ? "R3" : "R4", 64'(mem_rd_valid), 64'd1);
      check(mem_rd_addr == exp_addr, lvl == 0 ? "R3" : "R4", 64'(mem_rd_addr), 64'(exp_addr));
      for (int s = 0; s < T_STALL[v]; s++) begin
        @(negedge clk);
        check(mem_rd_valid && mem_rd_addr == exp_addr, "R10", 64'(mem_rd_addr), 64'(exp_addr));
      end
      mem_rd_ready = 1'b1;
      @(negedge clk);
      mem_rd_ready = 1'b0;
      check(mem_rd_valid == 1'b0, "R4", 64'(mem_rd_valid), 64'd0);
      if (T_NOISE[v] || collide) begin
        req_valid = 1'b1;
        req_va = collide ? cva : ~va;
        base_reg = collide ? cbase : ~base;
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data = T_DESC[v][lvl];
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data = '0;
      if (!collide) begin
        req_valid = 1'b0;
        req_va = '0;
        base_reg = '0;
      end
      if (!T_DESC[v][lvl][0]) begin
        ended = 1'b1;
        check(done == 1'b1, "R9", 64'(done), 64'd1);
        check(fill_fault == 1'b1, "R8", 64'(fill_fault), 64'd1);
        check(fill_fault_lvl == 2'(lvl), "R8", 64'(fill_fault_lvl), 64'(lvl));
        check(fill_ppn == '0 && fill_ng == 1'b0, "R8", 64'(fill_ppn), 64'd0);
        check(mem_rd_valid == 1'b0, "R8", 64'(mem_rd_valid), 64'd0);
      end else if (lvl == 3) begin
        ended = 1'b1;
        check(done == 1'b1, "R9", 64'(done), 64'd1);
        check(fill_fault == 1'b0, "R5", 64'(fill_fault), 64'd0);
        check(fill_ppn == T_DESC[v][3][47:12], "R5", 64'(fill_ppn), 64'(T_DESC[v][3][47:12]));
        check(fill_vpn == va[47:12], "R5", 64'(fill_vpn), 64'(va[47:12]));
        check(fill_ng == T_DESC[v][3][11], "R6", 64'(fill_ng), 64'(T_DESC[v][3][11]));
      end else begin
        check(done == 1'b0, "R9", 64'(done), 64'd0);
        tbl = T_DESC[v][lvl][47:12];
      end
    end
    check(fill_asid == base[63:48], "R7", 64'(fill_asid), 64'(base[63:48]));
    check(req_ready == 1'b0, "R2", 64'(req_ready), 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R9", 64'(done), 64'd0);
    check(req_ready == 1'b1, "R2", 64'(req_ready), 64'd1);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1", 64'(req_ready), 64'd1);
    check(done == 1'b0, "R1", 64'(done), 64'd0);
    check(mem_rd_valid == 1'b0, "R1", 64'(mem_rd_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_rd_valid == 1'b0 && done == 1'b0, "R1", 64'(mem_rd_valid), 64'd0);

    for (int v = 0; v < NV; v++) run_walk(v, 1'b0, '0, '0, 1'b0);

    // R2 / R9: next request raised during the leaf response and held through done
    run_walk(0, 1'b1, T_VA[5], T_BASE[5], 1'b0);
    run_walk(5, 1'b0, '0, '0, 1'b1);

    // R6: same walk again after a leaf with bit 11 set, flag must follow new leaf
    run_walk(1, 1'b0, '0, '0, 1'b0);
    run_walk(0, 1'b0, '0, '0, 1'b0);

    finish_run();
  end
endmodule